// File: doc/BRIEF.md
# Instruction Trap Entry Sequencer

This block carries a 32-bit processor core from the moment an instruction raises a trap to the moment the handler starts. A request carries a cause code, with a trap number when the cause is a software trap. The current status register, the address of the faulting instruction, the address of the next instruction, the vector table base and the supervisor stack pointer come with it. The block works out the vector number and builds an exception frame on the supervisor stack through a word write port. It then reads the handler address from the vector table through a read port. When it finishes it returns the new program counter, the new status register and the new stack pointer.

The block also tracks trace. If tracing was on for the instruction that trapped, a trace request stays pending while the handler runs. It is released only when the core reports that the return-from-exception has finished, so the handler itself is never traced.

The sequencer is a single state machine with these states:
- `S_IDLE`: waiting for a request. A request takes it to `S_WR_SR`.
- `S_WR_SR`, `S_WR_PC` and `S_WR_FMT`: each writes one frame word and moves on to the next state in that order.
- `S_WR_FAULT`: entered from `S_WR_FMT` for long frames only. Short frames go straight from `S_WR_FMT` to `S_FETCH`.
- `S_FETCH`: issues the vector table read, then goes to `S_LOAD`.
- `S_LOAD`: takes in the read data, then goes to `S_DONE`.
- `S_DONE`: pulses completion, then returns to `S_IDLE`.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause codes map to vector numbers as follows:
  - 0 is a software trap with vector 32 plus the 4-bit trap number.
  - 1 is an illegal instruction with vector 4.
  - 2 is a zero divisor with vector 5.
  - 3 is a bounds-check failure with vector 6.
  - 4 is a conditional or overflow trap with vector 7.
  - Codes 5 to 7 are treated as illegal, with vector 4.
- R2: The frame is 12 bytes for cause 0 and 16 bytes for every other cause. `new_ssp` equals `ssp_in` minus the frame size, and all frame writes land at or above `new_ssp`.
- R3: Frame words are written one per cycle, in the first cycles after acceptance:
  - `new_ssp+0` holds the saved status register, zero-extended.
  - `new_ssp+4` holds `next_pc`.
  - `new_ssp+8` holds the format/offset word: bits 15:12 are the format (0 for a short frame, 2 for a long frame) and bits 11:0 are the vector offset, which is the vector number times 4.
- R4: A long frame has a fourth write of `fault_pc` at `new_ssp+12`. A cause 0 frame has no fourth write.
- R5: After the frame writes, one read with `rd_en` high is issued at `vec_base` plus the vector offset. `rd_data` is taken the cycle after `rd_en`, and no write, read or done ever overlap.
- R6: `done` pulses for one cycle, two cycles after the read. Alongside it:
  - `new_pc` equals the data that was read.
  - `new_sr` equals the accepted `sr_in` with bit 13 (supervisor) set and bits 15:14 (trace enables) cleared.
  - `new_ssp` is as in R2.
- R7: `busy` is high from the cycle after acceptance through the `done` cycle, and low afterwards. A request is accepted only when the state is idle. Requests that arrive while busy, including in the `done` cycle, are ignored.
- R8: If `sr_in[15:14]` is not zero at acceptance, a trace is pending. The next `rte_done` then gives a one-cycle `trace_req` in the following cycle and clears the pending state.
- R9: An `rte_done` with no trace pending gives no `trace_req`, and `trace_req` never rises during handler entry.
- R10: During and right after reset, `busy`, `mem_we`, `rd_en`, `done` and `trace_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Trap request |
| req_cause | input | 3 | Cause code (R1) |
| req_trap_num | input | 4 | Software trap number |
| sr_in | input | 16 | Current status register |
| fault_pc | input | 32 | Address of the trapping instruction |
| next_pc | input | 32 | Address of the following instruction |
| vec_base | input | 32 | Vector table base address |
| ssp_in | input | 32 | Supervisor stack pointer |
| rte_done | input | 1 | Return-from-exception finished |
| mem_we | output | 1 | Frame word write strobe |
| mem_addr | output | 32 | Frame write byte address |
| mem_wdata | output | 32 | Frame write data |
| rd_en | output | 1 | Vector table read strobe |
| rd_addr | output | 32 | Vector table byte address |
| rd_data | input | 32 | Read data, valid the cycle after rd_en |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Entry complete pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Updated status register |
| new_ssp | output | 32 | Updated supervisor stack pointer |
| trace_req | output | 1 | Deferred trace exception request |

## Verification
The assertions check on every cycle that:
- writes happen only while busy;
- write, read and done are mutually exclusive;
- `done` and `trace_req` are single-cycle pulses;
- every `trace_req` follows an `rte_done`;
- the status register delivered with `done` has supervisor state set and tracing off;
- vector reads are word aligned.

Only the bench's scenarios, compared against a cycle-level reference model, can show the rest:
- the vector number for each cause;
- the order, addresses and contents of the frame words;
- the short versus long frame choice;
- the handler address;
- that requests arriving while busy are ignored;
- that trace is released only on a return with trace pending.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        CAUSE_SWTRAP  = 3'd0,
        CAUSE_ILLEGAL = 3'd1,
        CAUSE_ZDIV    = 3'd2,
        CAUSE_BOUNDS  = 3'd3,
        CAUSE_CONDTRP = 3'd4
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SR,
        S_WR_PC,
        S_WR_FMT,
        S_WR_FAULT,
        S_FETCH,
        S_LOAD,
        S_DONE
    } state_e;

    localparam logic [3:0] FMT_SHORT = 4'd0;
    localparam logic [3:0] FMT_LONG  = 4'd2;

endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
#(
    parameter int unsigned TRAPN_W = 4,
    parameter int unsigned VEC_W   = 8
) (
    input  logic [2:0]         cause,
    input  logic [TRAPN_W-1:0] trap_num,
    output logic [VEC_W-1:0]   vec_num,
    output logic               long_frame
);

    localparam logic [VEC_W-1:0] SW_BASE = VEC_W'(32);

    always_comb begin
        long_frame = 1'b1;
        case (cause)
            CAUSE_SWTRAP: begin
                vec_num    = SW_BASE + VEC_W'(trap_num);
                long_frame = 1'b0;
            end
            CAUSE_ZDIV:    vec_num = VEC_W'(5);
            CAUSE_BOUNDS:  vec_num = VEC_W'(6);
            CAUSE_CONDTRP: vec_num = VEC_W'(7);
            default:       vec_num = VEC_W'(4);
        endcase
    end

endmodule

// File: rtl/exc_trace_track.sv
module exc_trace_track (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rte,
    output logic trace_req
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            trace_req <= 1'b0;
        end else begin
            trace_req <= rte && pend_q;
            if (arm)
                pend_q <= 1'b1;
            else if (rte)
                pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SR_W     = 16,
    parameter int unsigned TRAPN_W  = 4,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned SUP_BIT  = 13,
    parameter int unsigned TRC_LO   = 14,
    parameter int unsigned TRC_HI   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cause,
    input  logic [TRAPN_W-1:0] req_trap_num,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [DATA_W-1:0] fault_pc,
    input  logic [DATA_W-1:0] next_pc,
    input  logic [DATA_W-1:0] vec_base,
    input  logic [DATA_W-1:0] ssp_in,
    input  logic              rte_done,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_en,
    output logic [DATA_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] new_pc,
    output logic [SR_W-1:0]   new_sr,
    output logic [DATA_W-1:0] new_ssp,
    output logic              trace_req
);

    localparam int unsigned OFF_W   = 12;
    localparam int unsigned OFF_PAD = OFF_W - VEC_W - 2;
    localparam logic [DATA_W-1:0] SHORT_BYTES = DATA_W'(12);
    localparam logic [DATA_W-1:0] LONG_BYTES  = DATA_W'(16);

    state_e state_q, state_d;

    logic [VEC_W-1:0]   vec_num;
    logic               long_frame;
    logic               accept;
    logic               trace_on;
    logic [VEC_W+1:0]   vec_off;
    logic [SR_W-1:0]    sr_next;

    logic [SR_W-1:0]    sr_q;
    logic [DATA_W-1:0]  npc_q, fpc_q, fetch_q, sp_q, fmtw_q, pc_q;
    logic [SR_W-1:0]    nsr_q;
    logic               long_q;

    exc_vector_calc #(
        .TRAPN_W (TRAPN_W),
        .VEC_W   (VEC_W)
    ) vcalc_i (
        .cause      (req_cause),
        .trap_num   (req_trap_num),
        .vec_num    (vec_num),
        .long_frame (long_frame)
    );

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign trace_on = |sr_in[TRC_HI:TRC_LO];
    assign vec_off  = {vec_num, 2'b00};

    always_comb begin
        sr_next = sr_in;
        sr_next[SUP_BIT] = 1'b1;
        sr_next[TRC_HI:TRC_LO] = '0;
    end

    exc_trace_track trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (accept && trace_on),
        .rte       (rte_done),
        .trace_req (trace_req)
    );

    // state register and captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sr_q    <= '0;
            npc_q   <= '0;
            fpc_q   <= '0;
            fetch_q <= '0;
            sp_q    <= '0;
            fmtw_q  <= '0;
            pc_q    <= '0;
            nsr_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sr_q    <= sr_in;
                npc_q   <= next_pc;
                fpc_q   <= fault_pc;
                long_q  <= long_frame;
                nsr_q   <= sr_next;
                fetch_q <= vec_base + DATA_W'(vec_off);
                sp_q    <= ssp_in - (long_frame ? LONG_BYTES : SHORT_BYTES);
                fmtw_q  <= DATA_W'({(long_frame ? FMT_LONG : FMT_SHORT),
                                    {OFF_PAD{1'b0}}, vec_off});
            end
            if (state_q == S_LOAD)
                pc_q <= rd_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_WR_SR;
            S_WR_SR:    state_d = S_WR_PC;
            S_WR_PC:    state_d = S_WR_FMT;
            S_WR_FMT:   state_d = long_q ? S_WR_FAULT : S_FETCH;
            S_WR_FAULT: state_d = S_FETCH;
            S_FETCH:    state_d = S_LOAD;
            S_LOAD:     state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = '0;
        rd_en     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_WR_SR: begin
                mem_we    = 1'b1;
                mem_wdata = DATA_W'(sr_q);
            end
            S_WR_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q + DATA_W'(4);
                mem_wdata = npc_q;
            end
            S_WR_FMT: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q + DATA_W'(8);
                mem_wdata = fmtw_q;
            end
            S_WR_FAULT: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q + DATA_W'(12);
                mem_wdata = fpc_q;
            end
            S_FETCH: rd_en = 1'b1;
            S_LOAD: ;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign rd_addr = fetch_q;
    assign busy    = (state_q != S_IDLE);
    assign new_pc  = pc_q;
    assign new_sr  = nsr_q;
    assign new_ssp = sp_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SR_W    = 16,
    parameter int unsigned SUP_BIT = 13,
    parameter int unsigned TRC_LO  = 14,
    parameter int unsigned TRC_HI  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              rd_en,
    input logic [1:0]        rd_lsb,
    input logic              busy,
    input logic              done,
    input logic [SR_W-1:0]   new_sr,
    input logic              rte_done,
    input logic              trace_req
);

    p_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, rd_en, done}));

    p_fetch_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_lsb == 2'b00));

    p_done_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_sr[SUP_BIT] && (new_sr[TRC_HI:TRC_LO] == '0)));

    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_trace_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |=> !trace_req);

    p_trace_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |-> $past(rte_done));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .DATA_W  (DATA_W),
    .SR_W    (SR_W),
    .SUP_BIT (SUP_BIT),
    .TRC_LO  (TRC_LO),
    .TRC_HI  (TRC_HI)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .rd_en     (rd_en),
    .rd_lsb    (rd_addr[1:0]),
    .busy      (busy),
    .done      (done),
    .new_sr    (new_sr),
    .rte_done  (rte_done),
    .trace_req (trace_req)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    localparam logic [31:0] RD_KEY = 32'h5A00_0001;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_cause;
    logic [3:0]  req_trap_num;
    logic [15:0] sr_in;
    logic [31:0] fault_pc, next_pc, vec_base, ssp_in;
    logic        rte_done;
    logic        mem_we, rd_en, busy, done, trace_req;
    logic [31:0] mem_addr, mem_wdata, rd_addr, new_pc, new_ssp;
    logic [31:0] rd_data;
    logic [15:0] new_sr;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
        .req_trap_num(req_trap_num), .sr_in(sr_in), .fault_pc(fault_pc),
        .next_pc(next_pc), .vec_base(vec_base), .ssp_in(ssp_in),
        .rte_done(rte_done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .new_pc(new_pc),
        .new_sr(new_sr), .new_ssp(new_ssp), .trace_req(trace_req)
    );

    // vector table model: data is available the cycle after the read strobe
    always @(posedge clk) begin
        if (rd_en) rd_data <= rd_addr ^ RD_KEY;
    end

    typedef struct {
        bit          bsy;
        bit          we;
        logic [31:0] waddr;
        logic [31:0] wdata;
        string       wtag;
        bit          re;
        logic [31:0] raddr;
        bit          dn;
        logic [31:0] pc;
        logic [15:0] sr;
        logic [31:0] ssp;
    } rec_t;

    rec_t exp_q[$];
    bit   model_idle = 1'b1;
    bit   trace_pend = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic rec_t blank();
        rec_t r;
        r.bsy = 1'b1; r.we = 1'b0; r.waddr = '0; r.wdata = '0; r.wtag = "";
        r.re = 1'b0; r.raddr = '0; r.dn = 1'b0; r.pc = '0; r.sr = '0; r.ssp = '0;
        return r;
    endfunction

    task automatic push_entry(input logic [2:0] c, input logic [3:0] n,
                              input logic [15:0] sr);
        int unsigned vec;
        bit lng;
        logic [31:0] sp, off, handler;
        rec_t r;
        case (c)
            3'd0: vec = 32 + n;     // R1 software trap
            3'd2: vec = 5;
            3'd3: vec = 6;
            3'd4: vec = 7;
            default: vec = 4;       // R1 illegal and unused codes
        endcase
        lng     = (c != 3'd0);
        sp      = ssp_in - (lng ? 32'd16 : 32'd12);
        off     = vec * 4;
        handler = (vec_base + off) ^ RD_KEY;
        r = blank(); r.we = 1; r.waddr = sp;      r.wdata = {16'h0, sr};  r.wtag = "R3"; exp_q.push_back(r);
        r = blank(); r.we = 1; r.waddr = sp + 4;  r.wdata = next_pc;      r.wtag = "R3"; exp_q.push_back(r);
        r = blank(); r.we = 1; r.waddr = sp + 8;
        r.wdata = {16'h0, (lng ? 4'd2 : 4'd0), off[11:0]};                r.wtag = "R3"; exp_q.push_back(r);
        if (lng) begin
            r = blank(); r.we = 1; r.waddr = sp + 12; r.wdata = fault_pc; r.wtag = "R4"; exp_q.push_back(r);
        end
        r = blank(); r.re = 1; r.raddr = vec_base + off; exp_q.push_back(r);
        r = blank(); exp_q.push_back(r);
        r = blank(); r.dn = 1; r.pc = handler;
        r.sr = (sr | 16'h2000) & 16'h3FFF; r.ssp = sp; exp_q.push_back(r);
        if (sr[15:14] != 2'b00) trace_pend = 1'b1;   // R8
    endtask

    task automatic compare(input rec_t e, input bit tr_exp);
        chk(busy == e.bsy, "R7 busy", 32'(busy), 32'(e.bsy));
        chk(mem_we == e.we, "R4 write strobe", 32'(mem_we), 32'(e.we));
        if (e.we && mem_we) begin
            chk(mem_addr == e.waddr, "R2 write address", mem_addr, e.waddr);
            chk(mem_wdata == e.wdata, e.wtag, mem_wdata, e.wdata);
        end
        chk(rd_en == e.re, "R5 read strobe", 32'(rd_en), 32'(e.re));
        if (e.re && rd_en)
            chk(rd_addr == e.raddr, "R5 vector address (R1 vector)", rd_addr, e.raddr);
        chk(done == e.dn, "R6 done", 32'(done), 32'(e.dn));
        if (e.dn && done) begin
            chk(new_pc == e.pc, "R6 new_pc", new_pc, e.pc);
            chk(new_sr == e.sr, "R6 new_sr", 32'(new_sr), 32'(e.sr));
            chk(new_ssp == e.ssp, "R2 new_ssp", new_ssp, e.ssp);
        end
        chk(trace_req == tr_exp, tr_exp ? "R8 trace_req" : "R9 trace_req",
            32'(trace_req), 32'(tr_exp));
    endtask

    task automatic step(input bit v, input logic [2:0] c, input logic [3:0] n,
                        input logic [15:0] sr, input bit rte);
        bit tnext;
        bit popped;
        rec_t e;
        req_valid = v; req_cause = c; req_trap_num = n; sr_in = sr; rte_done = rte;
        if (v && model_idle) push_entry(c, n, sr);
        tnext = rte ? trace_pend : 1'b0;
        if (rte) trace_pend = 1'b0;
        @(posedge clk);
        @(negedge clk);
        popped = (exp_q.size() > 0);
        if (popped) e = exp_q.pop_front();
        else begin e = blank(); e.bsy = 1'b0; end
        compare(e, tnext);
        model_idle = !popped && (exp_q.size() == 0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 3'd0, 4'd0, 16'h0, 0);
    endtask

    task automatic entry(input logic [2:0] c, input logic [3:0] n, input logic [15:0] sr);
        step(1, c, n, sr, 0);
        for (int i = 0; i < 12 && !model_idle; i++) step(0, 3'd7, 4'd9, 16'hFFFF, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_cause = 0; req_trap_num = 0; sr_in = 0;
        fault_pc = 32'h0000_1000; next_pc = 32'h0000_1004;
        vec_base = 32'h0000_0400; ssp_in = 32'h0000_8000; rte_done = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !rd_en && !done && !trace_req, "R10 in reset",
            {27'h0, busy, mem_we, rd_en, done, trace_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_we && !rd_en && !done && !trace_req, "R10 after reset",
            {27'h0, busy, mem_we, rd_en, done, trace_req}, 32'h0);

        // R1 software traps at both ends of the number range, short frames (R2, R3)
        entry(3'd0, 4'd0, 16'h0700);
        fault_pc = 32'h0000_2000; next_pc = 32'h0000_2002; ssp_in = 32'h0000_7FF0;
        entry(3'd0, 4'd15, 16'h001F);
        // R1 and R4 long-frame causes
        vec_base = 32'h0001_0000;
        entry(3'd1, 4'd3, 16'h0000);
        entry(3'd2, 4'd0, 16'h2004);
        fault_pc = 32'h00AB_CD00; next_pc = 32'h00AB_CD06;
        entry(3'd3, 4'd0, 16'h0000);
        entry(3'd4, 4'd0, 16'h0010);
        entry(3'd6, 4'd1, 16'h0000);   // unused code acts as illegal

        // R8 trace on: pending until return
        entry(3'd0, 4'd7, 16'h8000);
        idle(2);
        step(0, 3'd0, 4'd0, 16'h0, 1);   // rte with trace pending
        idle(2);
        step(0, 3'd0, 4'd0, 16'h0, 1);   // R9 second rte: nothing pending
        idle(1);
        entry(3'd2, 4'd0, 16'h4000);
        step(0, 3'd0, 4'd0, 16'h0, 1);
        idle(1);

        // R7 requests while busy and during done are ignored
        ssp_in = 32'h0000_6000;
        step(1, 3'd3, 4'd0, 16'h0000, 0);
        for (int i = 0; i < 6; i++) step(1, 3'd0, 4'(i), 16'hC000, 0);
        idle(3);
        // R9 no trace armed by the ignored requests
        step(0, 3'd0, 4'd0, 16'h0, 1);
        idle(2);

        // back-to-back requests held high
        for (int i = 0; i < 20; i++) step(1, 3'd0, 4'd5, 16'h0300, 0);
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule